// File: doc/BRIEF.md
# Control-Register Instruction Unit

This unit owns a 32-bit mode and status control word and executes the small family of control instructions that act on it. An instruction is presented as a decoded prefix byte and opcode byte, together with an optional immediate byte and the current HL (32-bit) and accumulator operand values. The unit can:

- load the control word from HL through byte lanes that depend on a long-word mode bit;
- set or clear the lock and long-word mode bits;
- set the sticky extend mode bit;
- copy scattered control-word bits into its S, Z, V and C condition flags;
- move three auxiliary 8-bit control registers to and from the accumulator, or load them from the immediate.

Instructions enter on a valid/ready channel. `ins_ready_o` is held high, so the unit never applies back-pressure and a transfer happens on every clock edge where `ins_valid_i` is high. Each transfer executes in that single edge. The results, `done_o` and `illegal_o` are visible in the following cycle. Back-to-back transfers are allowed, and they give back-to-back done cycles.

Top module: `cr_ctl_unit`

## Requirements
- R1: After reset the control word, all three auxiliary registers, the flag outputs and `acc_o` are zero, and `done_o` and `illegal_o` are low.
- R2: `ins_ready_o` is always high. `done_o` is high in exactly the cycles that follow a cycle with `ins_valid_i` high, and low in all other cycles.
- R3: Lock mode is control bit 1 and long-word mode is bit 6. Prefix 0xED with opcode 0xF7 sets bit 1, and prefix 0xDD with 0xF7 sets bit 6. Prefix 0xED with 0xFF clears bit 1, and prefix 0xDD with 0xFF clears bit 6.
- R4: Extend mode is bit 7. Prefix 0xFD with 0xF7 sets it, and no instruction clears it.
- R5: Prefix 0xED with 0xC8 copies HL[15:8] to control bits 15:8 and HL[0] to bit 0, and leaves bits 7:1 unchanged.
- R6: In that same load, if bit 6 is set before the load, HL[31:16] goes to bits 31:16. Otherwise HL[15:8] goes to both bits 31:24 and bits 23:16.
- R7: `flag_o` is ordered {S,Z,V,C}, with S at bit 3. Prefix 0xED with 0xCF sets S=bit 16, Z=bit 24, V=bit 0 and C=bit 8 of the control word.
- R8: Prefix 0xDD with 0xCF sets S=bit 7, Z=bit 6 and C=bit 1, and keeps V unchanged.
- R9: A prefix of the form 11ss1101 with ss≠00 selects auxiliary register ss. `aux_o` holds register ss in bits [8·ss-1 : 8·ss-8]. Opcode 0xD8 writes `acc_i` into the selected register, and 0xDA writes `imm_i` into it.
- R10: Opcode 0xD0 with such a prefix copies the selected auxiliary register to `acc_o`. `acc_o` keeps its value under every other instruction.
- R11: A prefix of the form 11001101 with 0xD0, 0xD8 or 0xDA is illegal, as is any prefix and opcode pair that none of R3 to R10 lists. An illegal instruction raises `illegal_o` with `done_o` and changes no control, auxiliary, flag or accumulator state.
- R12: Only the two test instructions change `flag_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ins_valid_i | input | 1 | Instruction valid |
| ins_ready_o | output | 1 | Instruction ready (always high) |
| pfx_i | input | 8 | First opcode byte |
| code_i | input | 8 | Second opcode byte |
| imm_i | input | AUX_W | Immediate byte |
| hl_i | input | 32 | HL operand |
| acc_i | input | AUX_W | Accumulator operand |
| ctl_o | output | 32 | Control word |
| aux_o | output | 3*AUX_W | Auxiliary registers 1..3, register 1 in the low lane |
| flag_o | output | 4 | Flags {S,Z,V,C} |
| acc_o | output | AUX_W | Accumulator result |
| done_o | output | 1 | Instruction completed (previous cycle) |
| illegal_o | output | 1 | Completed instruction was illegal |

## Verification
The bench builds the unit with the default auxiliary width of 8 bits. With that width, the full 256-value prefix space can be swept against every defined opcode, and the full 256-value opcode space against the four prefixes of interest. HL, accumulator and immediate values vary arithmetically between steps. Because the sweep order both sets and clears long-word mode, HL loads are seen with the mode on and with it off. The illegal select code 00 and every undefined pair are covered, with the complete state compared after each instruction.

// File: rtl/cr_pkg.sv
package cr_pkg;
  localparam int CR_W   = 32;
  localparam int FLAG_W = 4;
  localparam int SEL_W  = 2;
  localparam int AUX_N  = (1 << SEL_W) - 1;

  localparam logic [7:0] PFX_ED = 8'hED;
  localparam logic [7:0] PFX_DD = 8'hDD;
  localparam logic [7:0] PFX_FD = 8'hFD;

  localparam logic [7:0] OP_LDHL = 8'hC8;
  localparam logic [7:0] OP_SET  = 8'hF7;
  localparam logic [7:0] OP_CLR  = 8'hFF;
  localparam logic [7:0] OP_TST  = 8'hCF;
  localparam logic [7:0] OP_RDA  = 8'hD0;
  localparam logic [7:0] OP_WRA  = 8'hD8;
  localparam logic [7:0] OP_IMM  = 8'hDA;

  localparam int B_LOCK = 1;
  localparam int B_LW   = 6;
  localparam int B_XM   = 7;

  typedef enum logic [3:0] {
    K_LDHL, K_SETLK, K_SETLW, K_SETXM, K_CLRLK, K_CLRLW,
    K_BTST, K_MTST, K_AUXRD, K_AUXWR, K_AUXIM, K_ILL
  } kind_e;

  typedef struct packed {
    kind_e            kind;
    logic [SEL_W-1:0] sel;
  } dec_t;
endpackage

// File: rtl/cr_decode.sv
module cr_decode
  import cr_pkg::*;
(
  input  logic [7:0] pfx_i,
  input  logic [7:0] code_i,
  output dec_t       dec_o
);
  logic aux_form;
  assign aux_form = (pfx_i[7:6] == 2'b11) && (pfx_i[3:0] == 4'b1101) &&
                    (pfx_i[5:4] != 2'b00);

  always_comb begin
    dec_o.kind = K_ILL;
    dec_o.sel  = pfx_i[5:4];
    case (code_i)
      OP_LDHL: if (pfx_i == PFX_ED) dec_o.kind = K_LDHL;
      OP_SET: begin
        if (pfx_i == PFX_ED)      dec_o.kind = K_SETLK;
        else if (pfx_i == PFX_DD) dec_o.kind = K_SETLW;
        else if (pfx_i == PFX_FD) dec_o.kind = K_SETXM;
      end
      OP_CLR: begin
        if (pfx_i == PFX_ED)      dec_o.kind = K_CLRLK;
        else if (pfx_i == PFX_DD) dec_o.kind = K_CLRLW;
      end
      OP_TST: begin
        if (pfx_i == PFX_ED)      dec_o.kind = K_BTST;
        else if (pfx_i == PFX_DD) dec_o.kind = K_MTST;
      end
      OP_RDA: if (aux_form) dec_o.kind = K_AUXRD;
      OP_WRA: if (aux_form) dec_o.kind = K_AUXWR;
      OP_IMM: if (aux_form) dec_o.kind = K_AUXIM;
      default: dec_o.kind = K_ILL;
    endcase
  end
endmodule

// File: rtl/cr_mainreg.sv
module cr_mainreg
  import cr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_i,
  input  kind_e             kind_i,
  input  logic [CR_W-1:0]   hl_i,
  output logic [CR_W-1:0]   ctl_q,
  output logic [FLAG_W-1:0] flag_q
);
  logic [CR_W-1:0]   ctl_n;
  logic [FLAG_W-1:0] flag_n;

  always_comb begin
    ctl_n  = ctl_q;
    flag_n = flag_q;
    case (kind_i)
      K_LDHL: begin
        ctl_n[15:8] = hl_i[15:8];
        ctl_n[0]    = hl_i[0];
        if (ctl_q[B_LW]) ctl_n[31:16] = hl_i[31:16];
        else             ctl_n[31:16] = {hl_i[15:8], hl_i[15:8]};
      end
      K_SETLK: ctl_n[B_LOCK] = 1'b1;
      K_SETLW: ctl_n[B_LW]   = 1'b1;
      K_SETXM: ctl_n[B_XM]   = 1'b1;
      K_CLRLK: ctl_n[B_LOCK] = 1'b0;
      K_CLRLW: ctl_n[B_LW]   = 1'b0;
      K_BTST:  flag_n = {ctl_q[16], ctl_q[24], ctl_q[0], ctl_q[8]};
      K_MTST:  flag_n = {ctl_q[B_XM], ctl_q[B_LW], flag_q[1], ctl_q[B_LOCK]};
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      flag_q <= '0;
    end else if (fire_i) begin
      ctl_q  <= ctl_n;
      flag_q <= flag_n;
    end
  end
endmodule

// File: rtl/cr_auxbank.sv
module cr_auxbank
  import cr_pkg::*;
#(
  parameter int AUX_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fire_i,
  input  kind_e                  kind_i,
  input  logic [SEL_W-1:0]       sel_i,
  input  logic [AUX_W-1:0]       acc_i,
  input  logic [AUX_W-1:0]       imm_i,
  output logic [AUX_N*AUX_W-1:0] bank_o,
  output logic [AUX_W-1:0]       acc_q
);
  logic [AUX_W-1:0] rd_val;

  for (genvar k = 0; k < AUX_N; k++) begin : g_reg
    logic [AUX_W-1:0] r_q;
    logic             hit;
    assign hit = fire_i && (sel_i == SEL_W'(k + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     r_q <= '0;
      else if (hit && kind_i == K_AUXWR) r_q <= acc_i;
      else if (hit && kind_i == K_AUXIM) r_q <= imm_i;
    end
    assign bank_o[k*AUX_W +: AUX_W] = r_q;
  end

  always_comb begin
    rd_val = '0;
    for (int k = 0; k < AUX_N; k++)
      if (sel_i == SEL_W'(k + 1)) rd_val = bank_o[k*AUX_W +: AUX_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              acc_q <= '0;
    else if (fire_i && kind_i == K_AUXRD)    acc_q <= rd_val;
  end
endmodule

// File: rtl/cr_ctl_unit.sv
module cr_ctl_unit
  import cr_pkg::*;
#(
  parameter int AUX_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ins_valid_i,
  output logic                   ins_ready_o,
  input  logic [7:0]             pfx_i,
  input  logic [7:0]             code_i,
  input  logic [AUX_W-1:0]       imm_i,
  input  logic [31:0]            hl_i,
  input  logic [AUX_W-1:0]       acc_i,
  output logic [31:0]            ctl_o,
  output logic [3*AUX_W-1:0]     aux_o,
  output logic [3:0]             flag_o,
  output logic [AUX_W-1:0]       acc_o,
  output logic                   done_o,
  output logic                   illegal_o
);
  dec_t dec;
  logic accept, fire;

  assign ins_ready_o = 1'b1;
  assign accept      = ins_valid_i && ins_ready_o;
  assign fire        = accept && (dec.kind != K_ILL);

  cr_decode u_dec (.pfx_i(pfx_i), .code_i(code_i), .dec_o(dec));

  cr_mainreg u_main (
    .clk(clk), .rst_n(rst_n), .fire_i(fire), .kind_i(dec.kind),
    .hl_i(hl_i), .ctl_q(ctl_o), .flag_q(flag_o)
  );

  cr_auxbank #(.AUX_W(AUX_W)) u_aux (
    .clk(clk), .rst_n(rst_n), .fire_i(fire), .kind_i(dec.kind),
    .sel_i(dec.sel), .acc_i(acc_i), .imm_i(imm_i),
    .bank_o(aux_o), .acc_q(acc_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      done_o    <= accept;
      illegal_o <= accept && (dec.kind == K_ILL);
    end
  end
endmodule

// File: rtl/cr_ctl_chk.sv
module cr_ctl_chk #(
  parameter int AUX_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ins_valid_i,
  input logic               ins_ready_o,
  input logic [7:0]         pfx_i,
  input logic [7:0]         code_i,
  input logic [31:0]        ctl_o,
  input logic [3*AUX_W-1:0] aux_o,
  input logic [3:0]         flag_o,
  input logic [AUX_W-1:0]   acc_o,
  input logic               done_o,
  input logic               illegal_o
);
  // R2
  done_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid_i && ins_ready_o) |=> done_o);
  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_valid_i |=> !done_o);
  // R4
  xm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_o[7] |=> ctl_o[7]);
  // R11
  ill_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> ($stable(ctl_o) && $stable(aux_o) && $stable(flag_o) && $stable(acc_o)));
  // R12
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid_i && code_i != 8'hCF) |=> $stable(flag_o));
  // R6
  lw_off_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid_i && pfx_i == 8'hED && code_i == 8'hC8 && !ctl_o[6]) |=>
    (ctl_o[31:24] == ctl_o[23:16]));
  // R11
  ill_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> done_o);
endmodule

bind cr_ctl_unit cr_ctl_chk #(.AUX_W(AUX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ins_valid_i(ins_valid_i), .ins_ready_o(ins_ready_o),
  .pfx_i(pfx_i), .code_i(code_i), .ctl_o(ctl_o), .aux_o(aux_o),
  .flag_o(flag_o), .acc_o(acc_o), .done_o(done_o), .illegal_o(illegal_o)
);

// File: tb/sim_cr_ctl_unit.sv
module sim_cr_ctl_unit;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ins_valid_i = 1'b0;
  logic          ins_ready_o;
  logic [7:0]    pfx_i = '0, code_i = '0;
  logic [AW-1:0] imm_i = '0, acc_i = '0;
  logic [31:0]   hl_i = '0;
  logic [31:0]   ctl_o;
  logic [3*AW-1:0] aux_o;
  logic [3:0]    flag_o;
  logic [AW-1:0] acc_o;
  logic          done_o, illegal_o;

  int checks = 0;
  int fails  = 0;

  // model state
  logic [31:0]   m_ctl = '0;
  logic [23:0]   m_aux = '0;
  logic [3:0]    m_flag = '0;
  logic [7:0]    m_acc = '0;
  logic          m_ill = 1'b0;
  string         m_tag = "R1";

  always #5 clk = ~clk;

  cr_ctl_unit #(.AUX_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .ins_valid_i(ins_valid_i), .ins_ready_o(ins_ready_o),
    .pfx_i(pfx_i), .code_i(code_i), .imm_i(imm_i), .hl_i(hl_i), .acc_i(acc_i),
    .ctl_o(ctl_o), .aux_o(aux_o), .flag_o(flag_o), .acc_o(acc_o),
    .done_o(done_o), .illegal_o(illegal_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Reference behaviour written from the requirements
  task automatic model(input logic [7:0] p, input logic [7:0] c, input logic [7:0] im,
                       input logic [31:0] hl, input logic [7:0] a);
    bit aux_pfx;
    int s;
    aux_pfx = (p & 8'hCF) == 8'hCD;
    s = int'(p[5:4]);
    m_ill = 1'b0;
    if (p == 8'hED && c == 8'hC8) begin
      m_tag = m_ctl[6] ? "R5 R6 (lw on)" : "R5 R6 (lw off)";
      m_ctl = {m_ctl[6] ? hl[31:16] : {hl[15:8], hl[15:8]}, hl[15:8], m_ctl[7:1], hl[0]};
    end else if (c == 8'hF7 && p == 8'hED) begin m_tag = "R3"; m_ctl[1] = 1'b1; end
    else if (c == 8'hF7 && p == 8'hDD)     begin m_tag = "R3"; m_ctl[6] = 1'b1; end
    else if (c == 8'hF7 && p == 8'hFD)     begin m_tag = "R4"; m_ctl[7] = 1'b1; end
    else if (c == 8'hFF && p == 8'hED)     begin m_tag = "R3"; m_ctl[1] = 1'b0; end
    else if (c == 8'hFF && p == 8'hDD)     begin m_tag = "R3"; m_ctl[6] = 1'b0; end
    else if (c == 8'hCF && p == 8'hED) begin
      m_tag = "R7"; m_flag = {m_ctl[16], m_ctl[24], m_ctl[0], m_ctl[8]};
    end else if (c == 8'hCF && p == 8'hDD) begin
      m_tag = "R8"; m_flag[3] = m_ctl[7]; m_flag[2] = m_ctl[6]; m_flag[0] = m_ctl[1];
    end else if (aux_pfx && s != 0 && c == 8'hD0) begin
      m_tag = "R10"; m_acc = m_aux[8*(s-1) +: 8];
    end else if (aux_pfx && s != 0 && c == 8'hD8) begin
      m_tag = "R9"; m_aux[8*(s-1) +: 8] = a;
    end else if (aux_pfx && s != 0 && c == 8'hDA) begin
      m_tag = "R9"; m_aux[8*(s-1) +: 8] = im;
    end else begin
      m_tag = "R11"; m_ill = 1'b1;
    end
  endtask

  task automatic issue(input logic [7:0] p, input logic [7:0] c, input logic [7:0] im,
                       input logic [31:0] hl, input logic [7:0] a);
    @(negedge clk);
    chk(ins_ready_o === 1'b1, "R2", "ready", {31'd0, ins_ready_o}, 32'd1);
    ins_valid_i = 1'b1; pfx_i = p; code_i = c; imm_i = im; hl_i = hl; acc_i = a;
    model(p, c, im, hl, a);
    @(negedge clk);
    ins_valid_i = 1'b0;
    chk(done_o === 1'b1, "R2", "done", {31'd0, done_o}, 32'd1);
    chk(illegal_o === m_ill, "R11", "illegal", {31'd0, illegal_o}, {31'd0, m_ill});
    chk(ctl_o === m_ctl, m_tag, "ctl", ctl_o, m_ctl);
    chk(aux_o === m_aux, m_tag, "aux", {8'd0, aux_o}, {8'd0, m_aux});
    chk(flag_o === m_flag, (m_tag == "R7" || m_tag == "R8") ? m_tag : "R12", "flags",
        {28'd0, flag_o}, {28'd0, m_flag});
    chk(acc_o === m_acc, m_tag == "R10" ? "R10" : "R10 hold", "acc", {24'd0, acc_o}, {24'd0, m_acc});
    @(negedge clk);
    chk(done_o === 1'b0, "R2", "done pulse width", {31'd0, done_o}, 32'd0);
  endtask

  initial begin : watchdog
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : stim
    logic [7:0] codes [7];
    logic [7:0] pfxs [4];
    int n;
    codes = '{8'hC8, 8'hF7, 8'hFF, 8'hCF, 8'hD0, 8'hD8, 8'hDA};
    pfxs  = '{8'hED, 8'hDD, 8'hFD, 8'hCD};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ctl_o === 32'd0, "R1", "ctl", ctl_o, 0);
    chk(aux_o === 24'd0, "R1", "aux", {8'd0, aux_o}, 0);
    chk(flag_o === 4'd0, "R1", "flags", {28'd0, flag_o}, 0);
    chk(acc_o === 8'd0, "R1", "acc", {24'd0, acc_o}, 0);
    chk(done_o === 1'b0 && illegal_o === 1'b0, "R1", "done/illegal",
        {30'd0, done_o, illegal_o}, 0);
    rst_n = 1'b1;

    // directed corners
    issue(8'hED, 8'hC8, 8'h00, 32'hA5C3_7E81, 8'h00);  // R6 lw off: mirror 7E
    chk(ctl_o === 32'h7E7E_7E01, "R6", "mirror load", ctl_o, 32'h7E7E_7E01);
    issue(8'hDD, 8'hF7, 8'h00, 32'h0, 8'h00);           // set lw
    issue(8'hED, 8'hC8, 8'h00, 32'h1234_5678, 8'h00);  // R6 lw on
    chk(ctl_o === 32'h1234_5640, "R5", "wide load keeps bits 7:1", ctl_o, 32'h1234_5640);
    issue(8'hFD, 8'hF7, 8'h00, 32'h0, 8'h00);           // R4 set xm
    issue(8'hED, 8'hCF, 8'h00, 32'h0, 8'h00);           // R7
    issue(8'hDD, 8'hCF, 8'h00, 32'h0, 8'h00);           // R8
    issue(8'hCD, 8'hD8, 8'h00, 32'h0, 8'h77);           // R11 select 00
    issue(8'hFD, 8'hDA, 8'h3C, 32'h0, 8'h00);           // R9 immediate to reg 3
    issue(8'hFD, 8'hD0, 8'h00, 32'h0, 8'h00);           // R10 readback

    // sweep every prefix against every defined opcode
    n = 0;
    for (int p = 0; p < 256; p++) begin
      for (int c = 0; c < 7; c++) begin
        n++;
        issue(8'(p), codes[c], 8'(n * 37 + 5), 32'(n) * 32'h9E37_79B9, 8'(n * 11 + 3));
      end
    end
    // sweep every opcode against the key prefixes
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 256; c++) begin
        n++;
        issue(pfxs[p], 8'(c), 8'(n * 53 + 1), 32'(n) * 32'h85EB_CA6B, 8'(n * 29 + 7));
      end
    end
    // extend mode survives everything above; R4
    chk(ctl_o[7] === 1'b1, "R4", "extend sticky", {31'd0, ctl_o[7]}, 32'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule